// File: doc/BRIEF.md
# Bridge Configuration Header Registers

This block holds the bridge-specific registers of a type-1 configuration header: command, primary and secondary status, the three bus numbers, secondary latency timer, the I/O, memory and prefetchable base/limit pairs, their upper extensions, and bridge control. Access goes through a single-cycle, byte-enabled 32-bit port addressed by dword index. Reads are combinational. Writes take effect at the clock edge on which `cfg_wr` is high.

The window decoders elsewhere in the chip consume two strobes. `remap_o` pulses for one cycle after any write that touches a register feeding the forwarding windows, which tells the decoders to reload. `sec_rst_o` pulses for one cycle when software moves the secondary bus reset bit from 0 to 1. Reset clears all bridge state. The `fwd_off` input applies a preset that closes every window by driving the bases to their maximum and the limits to zero. Software can then open windows one at a time.

Top module: `bridge_cfg_regs`

## Requirements
- R1: A write with any enabled lane in bytes 0..1 of dword 1 (command) or in bytes 0..1 of dword 7 (I/O base/limit) makes `remap_o` high for exactly the next cycle.
- R2: A write with any enabled lane in dwords 8..12 (memory, prefetchable, prefetchable upper and I/O upper registers) makes `remap_o` high for the next cycle.
- R3: A write with any enabled lane in bytes 2..3 of dword 15 (bridge control) makes `remap_o` high for the next cycle.
- R4: `remap_o` stays low after writes that touch none of those lanes, for example the bus numbers in dword 6, or with all byte enables low.
- R5: `sec_rst_o` pulses for one cycle only when bridge control bit 6 (dword 15, data bit 22) changes from 0 to 1. Rewriting it as 1 while it is already 1 gives no pulse.
- R6: After reset the bus numbers, secondary latency, command, bridge control, the range fields of all base/limit registers and every upper register read zero.
- R7: A cycle with `fwd_off` high sets the I/O base nibble (dword 7 bits 7:4) to 0xF, the memory and prefetchable base fields (bits 15:4 of dwords 8 and 9) to 0xFFF, and clears the matching limit fields and both prefetchable upper dwords. It takes priority over a write in the same cycle and also pulses `remap_o`.
- R8: Dword 1 bits 31:16 and dword 7 bits 31:16 read 0x00A0 (66 MHz capable bit 5, fast back-to-back bit 7).
- R9: Dword 3 bits 22:16 read 0x01 (bridge header) and bit 23 reads the `MULTI_FN` parameter. Dword 2 bits 31:8 read 0x060400.
- R10: Each byte lane changes only when its enable is high. The writable bits are: command bits 2:0, all of dword 6, dword 7 bits 15:12 and 7:4, dwords 8 and 9 bits 31:20 and 15:4, all of dwords 10 to 12, and dword 15 bits 27:16.
- R11: The type nibbles read as constants: 0x1 in dword 7 bits 11:8 and 3:0, and 0x1 in dword 9 bits 19:16 and 3:0, whatever is written.
- R12: Dwords 4, 5, 13, 14 and all indices from 16 upward read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fwd_off | input | 1 | Apply the window-closing preset |
| cfg_wr | input | 1 | Write strobe |
| cfg_addr | input | ADDR_W | Dword index |
| cfg_be | input | 4 | Byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` |
| remap_o | output | 1 | Window reload strobe |
| sec_rst_o | output | 1 | Secondary bus reset pulse |

## Verification
On every cycle the assertions check the following. A reset pulse always coincides with a fresh rising edge of the bus reset bit. A held bit never pulses. Every remap strobe has a write or preset behind it. A bridge-control write always produces a strobe. The preset always leaves the memory window empty. Status and unimplemented reads hold their constant values. The bench's scenarios are needed to show the register contents after mixed byte enables. They also show the exact set of ranges that do or do not strobe, the reset values after a mid-run reset, and preset priority over a simultaneous write.

// File: rtl/bridge_cfg_regs.sv
module bridge_cfg_regs #(
  parameter int          ADDR_W    = 6,
  parameter logic [15:0] VENDOR_ID = 16'h1234,
  parameter logic [15:0] DEVICE_ID = 16'h0001,
  parameter logic [7:0]  REV_ID    = 8'h00,
  parameter bit          MULTI_FN  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwd_off,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              remap_o,
  output logic              sec_rst_o
);
  localparam logic [15:0] STAT     = 16'h00A0;
  localparam logic [3:0]  IO_TYPE  = 4'h1;
  localparam logic [3:0]  PF_TYPE  = 4'h1;
  localparam int          BRK_BIT  = 6;

  logic [2:0]  cmd;
  logic [7:0]  pri_bus, sec_bus, sub_bus, sec_lat;
  logic [3:0]  io_base, io_limit;
  logic [11:0] mem_base, mem_limit, pf_base, pf_limit;
  logic [31:0] pf_base_up, pf_limit_up;
  logic [15:0] io_base_up, io_limit_up;
  logic [11:0] bctl;

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[b*8 +: 8] = be[b] ? d[b*8 +: 8] : old[b*8 +: 8];
    return r;
  endfunction

  wire at1  = cfg_wr && (cfg_addr == ADDR_W'(1));
  wire at6  = cfg_wr && (cfg_addr == ADDR_W'(6));
  wire at7  = cfg_wr && (cfg_addr == ADDR_W'(7));
  wire at8  = cfg_wr && (cfg_addr == ADDR_W'(8));
  wire at9  = cfg_wr && (cfg_addr == ADDR_W'(9));
  wire at10 = cfg_wr && (cfg_addr == ADDR_W'(10));
  wire at11 = cfg_wr && (cfg_addr == ADDR_W'(11));
  wire at12 = cfg_wr && (cfg_addr == ADDR_W'(12));
  wire at15 = cfg_wr && (cfg_addr == ADDR_W'(15));

  wire win_hit = ((at1 || at7) && |cfg_be[1:0])
              || ((at8 || at9 || at10 || at11 || at12) && |cfg_be)
              || (at15 && |cfg_be[3:2]);

  wire brk_rise = at15 && cfg_be[2] && cfg_wdata[16+BRK_BIT] && !bctl[BRK_BIT] && !fwd_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remap_o   <= 1'b0;
      sec_rst_o <= 1'b0;
    end else begin
      remap_o   <= win_hit || fwd_off;
      sec_rst_o <= brk_rise;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd <= '0;
      pri_bus <= '0; sec_bus <= '0; sub_bus <= '0; sec_lat <= '0;
      io_base <= '0; io_limit <= '0;
      mem_base <= '0; mem_limit <= '0;
      pf_base <= '0; pf_limit <= '0;
      pf_base_up <= '0; pf_limit_up <= '0;
      io_base_up <= '0; io_limit_up <= '0;
      bctl <= '0;
    end else if (fwd_off) begin
      io_base     <= 4'hF;
      io_limit    <= 4'h0;
      mem_base    <= 12'hFFF;
      mem_limit   <= 12'h000;
      pf_base     <= 12'hFFF;
      pf_limit    <= 12'h000;
      pf_base_up  <= '0;
      pf_limit_up <= '0;
    end else begin
      if (at1 && cfg_be[0]) cmd <= cfg_wdata[2:0];
      if (at6) begin
        if (cfg_be[0]) pri_bus <= cfg_wdata[7:0];
        if (cfg_be[1]) sec_bus <= cfg_wdata[15:8];
        if (cfg_be[2]) sub_bus <= cfg_wdata[23:16];
        if (cfg_be[3]) sec_lat <= cfg_wdata[31:24];
      end
      if (at7) begin
        if (cfg_be[0]) io_base  <= cfg_wdata[7:4];
        if (cfg_be[1]) io_limit <= cfg_wdata[15:12];
      end
      if (at8) begin
        if (cfg_be[0]) mem_base[3:0]   <= cfg_wdata[7:4];
        if (cfg_be[1]) mem_base[11:4]  <= cfg_wdata[15:8];
        if (cfg_be[2]) mem_limit[3:0]  <= cfg_wdata[23:20];
        if (cfg_be[3]) mem_limit[11:4] <= cfg_wdata[31:24];
      end
      if (at9) begin
        if (cfg_be[0]) pf_base[3:0]   <= cfg_wdata[7:4];
        if (cfg_be[1]) pf_base[11:4]  <= cfg_wdata[15:8];
        if (cfg_be[2]) pf_limit[3:0]  <= cfg_wdata[23:20];
        if (cfg_be[3]) pf_limit[11:4] <= cfg_wdata[31:24];
      end
      if (at10) pf_base_up  <= merge(pf_base_up, cfg_wdata, cfg_be);
      if (at11) pf_limit_up <= merge(pf_limit_up, cfg_wdata, cfg_be);
      if (at12) begin
        if (cfg_be[0]) io_base_up[7:0]   <= cfg_wdata[7:0];
        if (cfg_be[1]) io_base_up[15:8]  <= cfg_wdata[15:8];
        if (cfg_be[2]) io_limit_up[7:0]  <= cfg_wdata[23:16];
        if (cfg_be[3]) io_limit_up[15:8] <= cfg_wdata[31:24];
      end
      if (at15) begin
        if (cfg_be[2]) bctl[7:0]  <= cfg_wdata[23:16];
        if (cfg_be[3]) bctl[11:8] <= cfg_wdata[27:24];
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      ADDR_W'(0):  cfg_rdata = {DEVICE_ID, VENDOR_ID};
      ADDR_W'(1):  cfg_rdata = {STAT, 13'd0, cmd};
      ADDR_W'(2):  cfg_rdata = {24'h060400, REV_ID};
      ADDR_W'(3):  cfg_rdata = {8'h00, MULTI_FN, 7'h01, 16'h0000};
      ADDR_W'(6):  cfg_rdata = {sec_lat, sub_bus, sec_bus, pri_bus};
      ADDR_W'(7):  cfg_rdata = {STAT, io_limit, IO_TYPE, io_base, IO_TYPE};
      ADDR_W'(8):  cfg_rdata = {mem_limit, 4'h0, mem_base, 4'h0};
      ADDR_W'(9):  cfg_rdata = {pf_limit, PF_TYPE, pf_base, PF_TYPE};
      ADDR_W'(10): cfg_rdata = pf_base_up;
      ADDR_W'(11): cfg_rdata = pf_limit_up;
      ADDR_W'(12): cfg_rdata = {io_limit_up, io_base_up};
      ADDR_W'(15): cfg_rdata = {4'h0, bctl, 16'h0000};
      default:     cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bridge_cfg_regs_chk.sv
module bridge_cfg_regs_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fwd_off,
  input logic              cfg_wr,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [3:0]        cfg_be,
  input logic [31:0]       cfg_rdata,
  input logic              remap_o,
  input logic              sec_rst_o,
  input logic              brk_bit,
  input logic [11:0]       mb,
  input logic [11:0]       ml
);
  p_secrst_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sec_rst_o |-> (brk_bit && !$past(brk_bit)));

  p_secrst_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_bit && $past(brk_bit) && $past(brk_bit, 2)) |-> !sec_rst_o);

  p_remap_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    remap_o |-> $past(fwd_off || (cfg_wr && cfg_be != 4'h0)));

  p_remap_bctl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == ADDR_W'(15) && cfg_be[3:2] != 2'b00) |=> remap_o);

  p_preset_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_off |=> (mb == 12'hFFF && ml == 12'h000));

  p_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == ADDR_W'(1)) |-> (cfg_rdata[31:16] == 16'h00A0));

  p_unimpl_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr >= ADDR_W'(16)) |-> (cfg_rdata == 32'h0));
endmodule

bind bridge_cfg_regs bridge_cfg_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fwd_off(fwd_off), .cfg_wr(cfg_wr),
  .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_rdata(cfg_rdata),
  .remap_o(remap_o), .sec_rst_o(sec_rst_o), .brk_bit(bctl[6]),
  .mb(mem_base), .ml(mem_limit)
);

// File: tb/tb_bridge_cfg_regs.sv
module tb_bridge_cfg_regs;
  logic clk = 0, rst_n = 0, fwd_off = 0, cfg_wr = 0;
  logic [5:0] cfg_addr = 0;
  logic [3:0] cfg_be = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic remap_o, sec_rst_o;
  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] st [16];

  bridge_cfg_regs dut (.*);

  always #5 clk = ~clk;

  function automatic logic [31:0] wm(int i);
    case (i)
      1: return 32'h0000_0007;
      6, 10, 11, 12: return 32'hFFFF_FFFF;
      7: return 32'h0000_F0F0;
      8, 9: return 32'hFFF0_FFF0;
      15: return 32'h0FFF_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] ro(int i);
    case (i)
      0: return 32'h0001_1234;
      1: return 32'h00A0_0000;
      2: return 32'h0604_0000;
      3: return 32'h0001_0000;
      7: return 32'h00A0_0101;
      9: return 32'h0001_0001;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(int i);
    if (i >= 16) return 32'h0;
    return (st[i] & wm(i)) | ro(i);
  endfunction

  function automatic logic exp_remap(int i, logic [3:0] be);
    if ((i == 1 || i == 7) && |be[1:0]) return 1;
    if (i >= 8 && i <= 12 && |be) return 1;
    if (i == 15 && |be[3:2]) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] bmask(logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) st[i] = 32'h0;
  endtask

  task automatic wr(input int i, input logic [3:0] be, input logic [31:0] d, input string tag);
    logic er, es;
    er = exp_remap(i, be);
    es = (i == 15) && be[2] && d[22] && !st[15][22];
    @(negedge clk);
    cfg_wr = 1; cfg_addr = 6'(i); cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0; cfg_be = 0;
    if (i < 16) st[i] = (st[i] & ~(bmask(be) & wm(i))) | (d & bmask(be) & wm(i));
    chk(remap_o == er, {tag, " remap"}, {31'd0, remap_o}, {31'd0, er});
    chk(sec_rst_o == es, {tag, " secrst"}, {31'd0, sec_rst_o}, {31'd0, es});
  endtask

  task automatic rd(input int i, input string tag);
    @(negedge clk);
    cfg_addr = 6'(i);
    #1;
    chk(cfg_rdata === exp_rd(i), tag, cfg_rdata, exp_rd(i));
  endtask

  task automatic preset(input logic with_write);
    @(negedge clk);
    fwd_off = 1;
    if (with_write) begin cfg_wr = 1; cfg_addr = 6'd8; cfg_be = 4'hF; cfg_wdata = 32'h1230_4560; end
    @(negedge clk);
    fwd_off = 0; cfg_wr = 0; cfg_be = 0;
    st[7] = (st[7] & ~32'h0000_F0F0) | 32'h0000_00F0;
    st[8] = 32'h0000_FFF0;
    st[9] = 32'h0000_FFF0;
    st[10] = 0; st[11] = 0;
    chk(remap_o == 1'b1, "R7 preset remap", {31'd0, remap_o}, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 20; i++) rd(i, "R6 reset value");
    rd(3, "R9 header type");
    rd(2, "R9 class code");
    rd(1, "R8 status");
    rd(7, "R8 secondary status");

    wr(1, 4'b0001, 32'hFFFF_FFFF, "R1 command");
    rd(1, "R10 command bits");
    wr(7, 4'b0010, 32'hFFFF_FFFF, "R1 io limit");
    rd(7, "R11 io type nibble");
    wr(1, 4'b1100, 32'hFFFF_FFFF, "R4 status lanes");
    wr(8, 4'b0100, 32'h00F0_0000, "R2 mem limit");
    wr(12, 4'b1000, 32'hAB00_0000, "R2 io upper");
    wr(9, 4'b1111, 32'hFFFF_FFFF, "R2 pref");
    rd(9, "R11 pref type nibble");
    wr(6, 4'b0101, 32'hFFFF_FFFF, "R4 bus numbers");
    rd(6, "R10 byte enables");
    wr(8, 4'b0000, 32'hFFFF_FFFF, "R4 no lanes");
    rd(8, "R10 no lanes");
    wr(15, 4'b0011, 32'hFFFF_FFFF, "R4 intr lanes");
    wr(15, 4'b1000, 32'h0F00_0000, "R3 bctl high");
    wr(15, 4'b0100, 32'h0040_0000, "R5 bus reset rise");
    wr(15, 4'b0100, 32'h0040_0000, "R5 bus reset held");
    wr(15, 4'b1000, 32'h0000_0000, "R5 other lane");
    wr(15, 4'b0100, 32'h0000_0000, "R5 bus reset clear");
    wr(15, 4'b0100, 32'h0040_0000, "R5 bus reset again");
    rd(15, "R3 bctl value");
    rd(4, "R12 bar zero");
    rd(40, "R12 high index");

    preset(1'b0);
    for (int i = 7; i < 12; i++) rd(i, "R7 preset value");
    wr(10, 4'hF, 32'h5555_AAAA, "R2 pref upper");
    preset(1'b1);
    rd(8, "R7 preset priority");
    rd(10, "R7 upper cleared");

    for (int n = 0; n < 600; n++) begin
      int i;
      i = ($urandom % 4 == 0) ? int'($urandom_range(16, 63)) : int'($urandom_range(0, 15));
      wr(i, 4'($urandom), $urandom, "R10 random write");
      rd(int'($urandom_range(0, 17)), "R10 random read");
    end

    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    model_reset();
    for (int i = 0; i < 16; i++) rd(i, "R6 mid-run reset");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule